// File: doc/BRIEF.md
# Laser Print Video Serializer

This block turns a stream of 16-bit raster words into the single serial video bit that a laser print engine consumes. It runs entirely on the engine's free-running video clock. A job begins with a start pulse that raises the print-request pin. The block then waits for the engine's page-sync edge. After that, every line-sync edge produces exactly one scanline: a programmable number of blank clocks, then a programmable number of pixels taken MSB first from the incoming words.

Pixel words arrive on a ready/valid port, and one word covers sixteen pixel clocks. If no word is offered when a bit is due, the pin shows blank video and a sticky underrun flag is raised. When the programmed number of lines has been sent, the request pin drops and the block goes idle. The page-sync, line-sync, request and video pins each have their own active-level select.

Top module: `lpv_video_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it, print_req shows its inactive level, video shows blank (the inverse of cfg_video_high), pix_ready is 0 and underrun is 0.
- R2: A job_start pulse in idle drives print_req to its active level on the following clock edge, and it stays active until the page is complete.
- R3: Line-sync edges that arrive after a job starts but before the first page-sync edge are ignored: video stays blank and no pixel word is taken.
- R4: Both sync pins pass through a two-flop synchronizer and act only on their active edge. The first pixel reaches the video pin at the clock edge that is skip+3 edges after the edge at which line sync is first sampled active.
- R5: Each line-sync active edge produces exactly one line of cfg_line_pixels pixel clocks, then blank video. Holding line sync active does not start another line, and an edge that arrives while a line is in progress is ignored.
- R6: Between the line-sync edge and the first pixel, video is blank for exactly cfg_left_skip clocks. A skip of 0 sends the first pixel straight away.
- R7: Each word supplies 16 pixels, bit 15 first, and a 1 bit is an active pixel. Bits of a word that are still unused at the end of a line are discarded, so the next line starts on a fresh word.
- R8: With cfg_video_high = 0, an active pixel is driven 0 and a blank pixel 1. With cfg_video_high = 1, both levels are inverted.
- R9: cfg_fsync_low, cfg_lsync_low and cfg_req_low each set to 1 make the matching pin active low; set to 0, the pin is active high.
- R10: A bit that is due while the word port is empty is driven blank and sets underrun. Underrun stays set until the next accepted job_start clears it.
- R11: After cfg_page_lines lines (at least 1), print_req returns to its inactive level, and further sync edges produce no video and take no words.
- R12: pix_ready is high only during a line when the shifter holds no unused bits, so one word is accepted per 16 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running video clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_start | input | 1 | Start pulse, accepted only in idle |
| cfg_line_pixels | input | LEN_W | Pixels per line (at least 1), captured at start |
| cfg_left_skip | input | SKIP_W | Blank clocks before the first pixel, captured at start |
| cfg_page_lines | input | LINE_W | Lines per page (at least 1), captured at start |
| cfg_fsync_low | input | 1 | 1 makes page sync active low |
| cfg_lsync_low | input | 1 | 1 makes line sync active low |
| cfg_req_low | input | 1 | 1 makes print_req active low |
| cfg_video_high | input | 1 | 1 makes an active pixel drive high |
| fsync_pin | input | 1 | Asynchronous page sync from the engine |
| lsync_pin | input | 1 | Asynchronous line sync from the engine |
| pix_valid | input | 1 | Pixel word offered |
| pix_data | input | PIX_W | Pixel word, MSB sent first |
| pix_ready | output | 1 | Word accepted on this clock if valid |
| print_req | output | 1 | Print request to the engine |
| video | output | 1 | Serial video bit |
| underrun | output | 1 | Sticky flag for starved pixels |

## Verification
The bench times every line from the cycle in which it drives line sync. An error of one register in the synchronizer or skip path therefore shifts the whole expected bit train and shows up as mismatches. It holds line sync active across a whole line, which would expose a design that triggers on level rather than on edge, and it uses a pixel count that is not a multiple of 16, which would expose a design that carries leftover bits into the next line. It also sends line sync before page sync and after the last line, where a loose sequencer would emit video or take words. The bench inverts every polarity on a second page, and it starves the word port to check that the design drives blank video and keeps underrun set until the next job.

// File: rtl/lpv_pkg.sv
// Package: shared types for the laser print video serializer.
// Assumes: nothing beyond standard SystemVerilog.
package lpv_pkg;

    // Page sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_FRAME = 3'd1,
        ST_WAIT_LINE  = 3'd2,
        ST_SKIP       = 3'd3,
        ST_SHIFT      = 3'd4
    } lpv_state_t;

    // Index of each engine sync input in the synchronizer bank.
    localparam int SYNC_FRAME = 0;
    localparam int SYNC_LINE  = 1;
    localparam int SYNC_COUNT = 2;

endpackage

// File: rtl/lpv_sync_edge.sv
// Module: lpv_sync_edge
// Brings NUM asynchronous pins into the clk domain through a STAGES-deep
// flop chain. Each pin is first normalized to active-high using its invert
// bit, and a one-cycle pulse is produced on each active edge.
// Assumes: the invert bits change only while the pins sit at their idle level.
module lpv_sync_edge #(
    parameter int NUM    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] pin_raw,
    input  logic [NUM-1:0] pin_invert,
    output logic [NUM-1:0] edge_pulse
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < NUM; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the normalized pin level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], pin_raw[g] ^ pin_invert[g]};
                prev  <= chain[LAST];
            end
        end

        // Rising edge of the synchronized, normalized level.
        assign edge_pulse[g] = chain[LAST] & ~prev;
    end

endmodule

// File: rtl/lpv_word_shifter.sv
// Module: lpv_word_shifter
// Holds one pixel word and hands out its bits MSB first, one per enabled
// clock. When empty during a line it takes a new word from the ready/valid
// port and uses its top bit in the same clock. At line end, unused bits are
// dropped.
// Assumes: shift_en is high only for pixel clocks of a line.
module lpv_word_shifter #(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             line_last,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic             pix_ready,
    output logic             pix_bit,
    output logic             starve
);

    localparam int CNT_W = $clog2(PIX_W + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PIX_W - 1);

    logic [PIX_W-1:0] sreg;
    logic [CNT_W-1:0] bits_left;
    logic             empty;

    assign empty     = (bits_left == '0);
    assign pix_ready = shift_en & empty;
    assign starve    = shift_en & empty & ~pix_valid;

    // Select the bit due this clock: held word, fresh word, or nothing.
    always_comb begin
        if (!shift_en)  pix_bit = 1'b0;
        else if (empty) pix_bit = pix_valid & pix_data[PIX_W-1];
        else            pix_bit = sreg[PIX_W-1];
    end

    // Advance the held word, load on demand, and discard leftovers at line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg      <= '0;
            bits_left <= '0;
        end else begin
            if (shift_en) begin
                if (!empty) begin
                    sreg      <= sreg << 1;
                    bits_left <= bits_left - 1'b1;
                end else if (pix_valid) begin
                    sreg      <= pix_data << 1;
                    bits_left <= RELOAD;
                end
            end
            if (line_last) begin
                bits_left <= '0;
            end
        end
    end

endmodule

// File: rtl/lpv_line_sequencer.sv
// Module: lpv_line_sequencer
// Page and line state machine. It captures the job settings at start, waits
// for page sync, then for each line-sync pulse counts the blank lead-in and
// the pixel clocks. After the last line of the page it returns to idle.
// Assumes: pixel count and line count are at least 1.
module lpv_line_sequencer
    import lpv_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int SKIP_W = 12,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [LEN_W-1:0]  cfg_line_pixels,
    input  logic [SKIP_W-1:0] cfg_left_skip,
    input  logic [LINE_W-1:0] cfg_page_lines,
    input  logic              frame_edge,
    input  logic              line_edge,
    output logic              busy,
    output logic              job_accept,
    output logic              shift_en,
    output logic              line_last
);

    localparam int CNT_W = (LEN_W > SKIP_W) ? LEN_W : SKIP_W;

    lpv_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    logic [SKIP_W-1:0] skip_q;
    logic [LINE_W-1:0] lines_q;
    logic [LINE_W-1:0] line_cnt;
    logic              cnt_one;

    assign cnt_one    = (cnt == CNT_W'(1));
    assign busy       = (state != ST_IDLE);
    assign job_accept = (state == ST_IDLE) & job_start;
    assign shift_en   = (state == ST_SHIFT);
    assign line_last  = shift_en & cnt_one;

    // Step through idle, page wait, line wait, lead-in and pixel phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            skip_q   <= '0;
            lines_q  <= '0;
            line_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (job_start) begin
                        len_q    <= cfg_line_pixels;
                        skip_q   <= cfg_left_skip;
                        lines_q  <= cfg_page_lines;
                        line_cnt <= '0;
                        state    <= ST_WAIT_FRAME;
                    end
                end
                ST_WAIT_FRAME: begin
                    if (frame_edge) state <= ST_WAIT_LINE;
                end
                ST_WAIT_LINE: begin
                    if (line_edge) begin
                        if (skip_q != '0) begin
                            cnt   <= CNT_W'(skip_q);
                            state <= ST_SKIP;
                        end else begin
                            cnt   <= CNT_W'(len_q);
                            state <= ST_SHIFT;
                        end
                    end
                end
                ST_SKIP: begin
                    if (cnt_one) begin
                        cnt   <= CNT_W'(len_q);
                        state <= ST_SHIFT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_one) begin
                        if (line_cnt == lines_q - 1'b1) begin
                            state <= ST_IDLE;
                        end else begin
                            line_cnt <= line_cnt + 1'b1;
                            state    <= ST_WAIT_LINE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpv_video_serializer.sv
// Module: lpv_video_serializer (top)
// Serializes pixel words onto one video pin, framed by the engine's page
// and line sync. It applies the programmed polarity to every engine pin and
// keeps a sticky underrun flag.
// Assumes: clk is the engine video clock; the polarity selects are static
// while a job runs.
module lpv_video_serializer
    import lpv_pkg::*;
#(
    parameter int PIX_W  = 16,
    parameter int LEN_W  = 16,
    parameter int SKIP_W = 12,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [LEN_W-1:0]  cfg_line_pixels,
    input  logic [SKIP_W-1:0] cfg_left_skip,
    input  logic [LINE_W-1:0] cfg_page_lines,
    input  logic              cfg_fsync_low,
    input  logic              cfg_lsync_low,
    input  logic              cfg_req_low,
    input  logic              cfg_video_high,
    input  logic              fsync_pin,
    input  logic              lsync_pin,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              pix_ready,
    output logic              print_req,
    output logic              video,
    output logic              underrun
);

    logic [SYNC_COUNT-1:0] sync_raw;
    logic [SYNC_COUNT-1:0] sync_inv;
    logic [SYNC_COUNT-1:0] sync_edge;
    logic busy, job_accept, shift_en, line_last;
    logic pix_bit, starve;
    logic video_act_q;
    logic underrun_q;

    assign sync_raw[SYNC_FRAME] = fsync_pin;
    assign sync_raw[SYNC_LINE]  = lsync_pin;
    assign sync_inv[SYNC_FRAME] = cfg_fsync_low;
    assign sync_inv[SYNC_LINE]  = cfg_lsync_low;

    lpv_sync_edge #(.NUM(SYNC_COUNT), .STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_raw    (sync_raw),
        .pin_invert (sync_inv),
        .edge_pulse (sync_edge)
    );

    lpv_line_sequencer #(.LEN_W(LEN_W), .SKIP_W(SKIP_W), .LINE_W(LINE_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .job_start       (job_start),
        .cfg_line_pixels (cfg_line_pixels),
        .cfg_left_skip   (cfg_left_skip),
        .cfg_page_lines  (cfg_page_lines),
        .frame_edge      (sync_edge[SYNC_FRAME]),
        .line_edge       (sync_edge[SYNC_LINE]),
        .busy            (busy),
        .job_accept      (job_accept),
        .shift_en        (shift_en),
        .line_last       (line_last)
    );

    lpv_word_shifter #(.PIX_W(PIX_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .line_last (line_last),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .pix_bit   (pix_bit),
        .starve    (starve)
    );

    // Register the active/blank decision for this clock's video bit.
    always_ff @(posedge clk) begin
        if (!rst_n) video_act_q <= 1'b0;
        else        video_act_q <= pix_bit;
    end

    // Sticky starvation flag, cleared when a new job is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)          underrun_q <= 1'b0;
        else if (job_accept) underrun_q <= 1'b0;
        else if (starve)     underrun_q <= 1'b1;
    end

    assign video     = video_act_q ? cfg_video_high : ~cfg_video_high;
    assign print_req = busy ^ cfg_req_low;
    assign underrun  = underrun_q;

endmodule

// File: rtl/lpv_checker.sv
// Module: lpv_checker
// Port-level temporal properties of the video serializer, attached by bind.
// Assumes: it is bound to lpv_video_serializer with matching port names.
module lpv_checker (
    input logic clk,
    input logic rst_n,
    input logic job_start,
    input logic cfg_req_low,
    input logic cfg_video_high,
    input logic pix_valid,
    input logic pix_ready,
    input logic print_req,
    input logic video,
    input logic underrun
);

    logic req_active;
    assign req_active = print_req ^ cfg_req_low;

    // R12: words are requested only while a job is running.
    assert_ready_in_job_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> req_active);

    // R7: a taken word covers the next clocks, so no back-to-back request.
    assert_word_spans_clocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && pix_valid) |=> !pix_ready);

    // R10: underrun holds until a start pulse.
    assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !job_start) |=> underrun);

    // R10: underrun rises only after a request that found no word.
    assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(pix_ready && !pix_valid));

    // R8: outside a job, video sits at the blank level.
    assert_idle_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_active && $past(!req_active)) |-> (video == !cfg_video_high));

endmodule

bind lpv_video_serializer lpv_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .job_start      (job_start),
    .cfg_req_low    (cfg_req_low),
    .cfg_video_high (cfg_video_high),
    .pix_valid      (pix_valid),
    .pix_ready      (pix_ready),
    .print_req      (print_req),
    .video          (video),
    .underrun       (underrun)
);

// File: tb/lpv_video_serializer_bench.sv
// Scoreboard bench: line tasks push the expected video levels per cycle,
// and a monitor pops and compares them at falling clock edges.
module lpv_video_serializer_bench;

    localparam int PIX_W = 16, LEN_W = 16, SKIP_W = 12, LINE_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic job_start = 1'b0;
    logic [LEN_W-1:0]  cfg_line_pixels = '0;
    logic [SKIP_W-1:0] cfg_left_skip = '0;
    logic [LINE_W-1:0] cfg_page_lines = '0;
    logic cfg_fsync_low = 1'b1, cfg_lsync_low = 1'b1;
    logic cfg_req_low = 1'b0, cfg_video_high = 1'b0;
    logic fsync_pin = 1'b1, lsync_pin = 1'b1;
    logic pix_valid;
    logic [PIX_W-1:0] pix_data;
    logic pix_ready, print_req, video, underrun;

    int compared = 0, mismatched = 0;
    int pc = 0;
    int mon_start = 0;
    int widx = 0, avail = 1000, exp_word = 0;
    bit took = 1'b0;
    logic exp_q[$];
    string tag_q[$];

    lpv_video_serializer #(.PIX_W(PIX_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W), .LINE_W(LINE_W))
    u_lpv_video_serializer (
        .clk(clk), .rst_n(rst_n), .job_start(job_start),
        .cfg_line_pixels(cfg_line_pixels), .cfg_left_skip(cfg_left_skip),
        .cfg_page_lines(cfg_page_lines), .cfg_fsync_low(cfg_fsync_low),
        .cfg_lsync_low(cfg_lsync_low), .cfg_req_low(cfg_req_low),
        .cfg_video_high(cfg_video_high), .fsync_pin(fsync_pin), .lsync_pin(lsync_pin),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .print_req(print_req), .video(video), .underrun(underrun)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [15:0] wordf(int i);
        return 16'hB2E7 ^ 16'(i * 16'h3A95) ^ 16'(i << 3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Posedge counter used to time the expected bit train.
    initial forever begin
        @(posedge clk);
        pc = pc + 1;
    end

    // Word feeder: advance after each accepted handshake.
    initial begin
        pix_data  = wordf(0);
        pix_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (took) widx = widx + 1;
            pix_data  = wordf(widx);
            pix_valid = (widx < avail);
            took      = pix_valid && pix_ready;
        end
    end

    // Monitor: compare video against the scoreboard queue.
    initial forever begin
        @(negedge clk);
        if (exp_q.size() > 0 && pc >= mon_start) begin
            logic e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(video), 32'(e));
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); job_start = 1'b1;
        @(negedge clk); job_start = 1'b0;
    endtask

    task automatic pulse_fsync();
        @(negedge clk); fsync_pin = ~cfg_fsync_low;
        cycles(3);      fsync_pin = cfg_fsync_low;
        cycles(6);
    endtask

    // R4 R5 R6 R7: drive one line sync, push the expected train, hold the pin.
    task automatic run_line(int skip, int len, string tag);
        logic blank;
        blank = ~cfg_video_high;
        @(negedge clk);
        lsync_pin = ~cfg_lsync_low;
        mon_start = pc + 4;
        for (int i = 0; i < skip; i++) begin exp_q.push_back(blank); tag_q.push_back({tag, " R6 skip"}); end
        for (int j = 0; j < len; j++) begin
            int w;
            logic b;
            w = exp_word + j / 16;
            b = (w < avail) ? wordf(w)[15 - (j % 16)] : 1'b0;
            exp_q.push_back(b ? cfg_video_high : blank);
            tag_q.push_back({tag, " R7 pixel"});
        end
        exp_q.push_back(blank); tag_q.push_back({tag, " R5 line end"});
        exp_q.push_back(blank); tag_q.push_back({tag, " R5 no retrigger"});
        cycles(skip + len + 12);   // R5: pin stays active across the whole line
        lsync_pin = cfg_lsync_low;
        cycles(6);
        check({tag, " R5 queue drained"}, 32'(exp_q.size()), 0);
        exp_word = exp_word + (len + 15) / 16;
    endtask

    initial begin
        int snap;
        cycles(5);
        // R1: reset state
        check("R1 print_req", 32'(print_req), 0);
        check("R1 video", 32'(video), 1);
        check("R1 pix_ready", 32'(pix_ready), 0);
        check("R1 underrun", 32'(underrun), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 print_req after reset", 32'(print_req), 0);
        check("R1 video after reset", 32'(video), 1);

        // Job 1: default polarities, 2 lines of 20 pixels, skip 3
        cfg_line_pixels = 20; cfg_left_skip = 3; cfg_page_lines = 2;
        pulse_start();
        check("R2 print_req active", 32'(print_req), 1);
        // R3: line sync before page sync is ignored
        snap = widx;
        @(negedge clk); lsync_pin = 1'b0;
        cycles(3); lsync_pin = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R3 no video before page sync", 32'(video), 1);
        end
        check("R3 no word taken", 32'(widx), 32'(snap));
        pulse_fsync();
        run_line(3, 20, "job1 line1");
        check("R2 request held between lines", 32'(print_req), 1);
        check("R7 leftover discarded (words used)", 32'(widx), 2);
        run_line(3, 20, "job1 line2");
        check("R11 request released", 32'(print_req), 0);
        check("R10 no underrun when fed", 32'(underrun), 0);
        // R11: later line sync does nothing
        snap = widx;
        @(negedge clk); lsync_pin = 1'b0;
        cycles(3); lsync_pin = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R11 no video after page", 32'(video), 1);
        end
        check("R11 no word after page", 32'(widx), 32'(snap));

        // Job 2: every polarity inverted, 1 line of 16 pixels, skip 2
        @(negedge clk);
        cfg_fsync_low = 1'b0; fsync_pin = 1'b0;
        cfg_lsync_low = 1'b0; lsync_pin = 1'b0;
        cfg_req_low = 1'b1; cfg_video_high = 1'b1;
        cfg_line_pixels = 16; cfg_left_skip = 2; cfg_page_lines = 1;
        @(negedge clk);
        check("R9 request idle level inverted", 32'(print_req), 1);
        check("R8 blank level inverted", 32'(video), 0);
        pulse_start();
        check("R9 request active low", 32'(print_req), 0);
        pulse_fsync();
        run_line(2, 16, "job2 inverted");
        check("R11 inverted request released", 32'(print_req), 1);

        // Job 3: default polarities, starve the word port
        @(negedge clk);
        cfg_fsync_low = 1'b1; fsync_pin = 1'b1;
        cfg_lsync_low = 1'b1; lsync_pin = 1'b1;
        cfg_req_low = 1'b0; cfg_video_high = 1'b0;
        cfg_line_pixels = 40; cfg_left_skip = 1; cfg_page_lines = 1;
        avail = widx + 2;
        pulse_start();
        pulse_fsync();
        run_line(1, 40, "job3 starved");
        check("R10 underrun set", 32'(underrun), 1);
        cycles(4);
        check("R10 underrun sticky", 32'(underrun), 1);
        pulse_start();
        check("R10 underrun cleared by start", 32'(underrun), 0);
        check("R2 request for job4", 32'(print_req), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #3_000_000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule